// File: doc/BRIEF.md
# Power Transition Script Sequencer

This block holds small power-transition programs in an on-chip byte store and plays one back whenever a power event asks for it. Each program step produces a 16-bit resource message for a downstream regulator controller. A host fills the store one byte at a time. It first writes a byte address, then writes the data byte. The host also sets one entry pointer for each kind of transition: entering sleep, waking processor groups 1 and 2, waking processor group 3, and warm reset.

A step occupies four bytes. When the sequencer runs a step, it presents that step's message on a valid/ready port. After the message is accepted, it waits the step's delay, counted in ticks of the 32 kHz slow clock. It then moves to the step named by the link byte. A link of 0x3F or above ends the program. The entry pointers and the per-group warm-reset enables can only be written after a two-key unlock sequence.

Top module: `pse_top`

## Requirements
- R1: After reset, msg_valid and busy are 0. Every entry pointer holds 0x3F and every warm-reset enable is 0.
- R2: A write to an entry pointer (cfg_sel 4 + transition code) or to a group control register (cfg_sel 8..10) takes effect only while unlocked. To unlock, write 0xC0 and then 0x0C to the key register (cfg_sel 0). Writing 0x00 to the key register locks again.
- R3: The unlock attempt restarts and the block stays locked if 0x0C arrives first, or if any other write comes between 0xC0 and 0x0C.
- R4: A write to cfg_sel 2 stores the data byte at the byte address last written to cfg_sel 1. Step i uses bytes 4i to 4i+3, in this order: message high byte, message low byte, delay, link.
- R5: If a transition event is high at clock edge k and the block is idle, msg_valid is high after edge k+1 and carries the first step's message.
- R6: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_data does not change.
- R7: Once a step's message is accepted, the next step's message becomes valid after exactly as many slow ticks as the step's delay byte. A delay of 0 presents the next message in the cycle right after acceptance.
- R8: A link byte of 0x3F or above ends the program. The block goes idle (busy 0) after that step's delay, and no further message is sent.
- R9: An event whose entry pointer holds 0x3F sends no message.
- R10: A warm-reset request from group g (ev_warm[g]) is served only if bit 4 of that group's control register (cfg_sel 8+g) is set.
- R11: Pending events are served in this order: warm reset (code 3), then group 1/2 wake (code 2), then group 3 wake (code 1), then sleep (code 0). An event that arrives while a program runs waits until the program ends.
- R12: Writes to cfg_sel 2 are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per 32 kHz slow-clock period |
| cfg_wr_en | input | 1 | Host register write strobe |
| cfg_sel | input | 4 | Host register select |
| cfg_wdata | input | 8 | Host write data |
| ev_sleep | input | 1 | Enter-sleep event pulse (code 0) |
| ev_wake3 | input | 1 | Group 3 wake event pulse (code 1) |
| ev_wake12 | input | 1 | Group 1/2 wake event pulse (code 2) |
| ev_warm | input | 3 | Per-group warm-reset request pulses (code 3) |
| msg_valid | output | 1 | Resource message valid |
| msg_ready | input | 1 | Resource message accepted |
| msg_data | output | 16 | Resource message |
| busy | output | 1 | A program is running |

## Verification
The first message of a program is due two clock edges after the event is sampled. The bench checks this by looking at the negative edges one and two cycles after the pulse. Message order and content go through a scoreboard that compares each handshake as it occurs, so back-pressure does not shift any expectation. The delay between steps is checked by counting the slow ticks that are sampled between one handshake and the next rise of msg_valid; the count must equal the delay byte. Requirements that something is ignored are checked by the absence of handshakes, and by replaying a program after the ignored write.

// File: rtl/pse_pkg.sv
package pse_pkg;
    localparam int IDX_W  = 6;
    localparam int ADDR_W = IDX_W + 2;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MSG_W  = 16;
    localparam int N_GRP  = 3;
    localparam int N_TR   = 4;
    localparam int SEL_W  = 4;
    localparam int WARM_EN_BIT = 4;

    localparam logic [IDX_W-1:0] END_IDX = '1;
    localparam logic [7:0] KEY_A = 8'hC0;
    localparam logic [7:0] KEY_B = 8'h0C;

    localparam logic [SEL_W-1:0] SEL_KEY   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_MADDR = 4'd1;
    localparam logic [SEL_W-1:0] SEL_MDATA = 4'd2;
    localparam int               SEL_PTR0  = 4;
    localparam int               SEL_GRP0  = 8;

    // code order is service priority: higher code wins
    typedef enum logic [1:0] {
        TR_SLEEP  = 2'd0,
        TR_WAKE3  = 2'd1,
        TR_WAKE12 = 2'd2,
        TR_WARM   = 2'd3
    } trans_e;

    typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_e;
    typedef enum logic [1:0] {WK_IDLE, WK_SEND, WK_WAIT} walk_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] dly;
        logic [7:0] nxt;
    } step_t;

    function automatic logic is_end(input logic [7:0] link);
        return link >= 8'(END_IDX);
    endfunction

    function automatic logic [ADDR_W-1:0] field_addr(input logic [IDX_W-1:0] idx,
                                                     input logic [1:0] fld);
        return {idx, fld};
    endfunction
endpackage

// File: rtl/pse_host_regs.sv
module pse_host_regs
    import pse_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [7:0]                    wr_data,
    input  logic                          busy,
    output logic [N_TR-1:0][IDX_W-1:0]    start_ptr,
    output logic [N_GRP-1:0]              warm_en,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [7:0]                    mem_wdata
);
    lock_e lock_q, lock_d;
    logic  key_wr;
    logic  cfg_ok;

    assign key_wr = wr_en && (wr_sel == SEL_KEY);
    assign cfg_ok = (lock_q == LK_OPEN);

    always_comb begin
        lock_d = lock_q;
        if (wr_en) begin
            case (lock_q)
                LK_SHUT: if (key_wr && wr_data == KEY_A) lock_d = LK_HALF;
                LK_HALF: begin
                    if (key_wr && wr_data == KEY_B)      lock_d = LK_OPEN;
                    else if (key_wr && wr_data == KEY_A) lock_d = LK_HALF;
                    else                                 lock_d = LK_SHUT;
                end
                LK_OPEN: if (key_wr && wr_data == 8'h00) lock_d = LK_SHUT;
                default: lock_d = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lock_q <= LK_SHUT;
        else     lock_q <= lock_d;
    end

    for (genvar t = 0; t < N_TR; t++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                start_ptr[t] <= END_IDX;
            else if (wr_en && cfg_ok && wr_sel == SEL_W'(SEL_PTR0 + t))
                start_ptr[t] <= wr_data[IDX_W-1:0];
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst)
                warm_en[g] <= 1'b0;
            else if (wr_en && cfg_ok && wr_sel == SEL_W'(SEL_GRP0 + g))
                warm_en[g] <= wr_data[WARM_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mem_addr <= '0;
        else if (wr_en && wr_sel == SEL_MADDR)
            mem_addr <= wr_data[ADDR_W-1:0];
    end

    assign mem_we    = wr_en && (wr_sel == SEL_MDATA) && !busy;
    assign mem_wdata = wr_data;

    assert_locked_ptr_R2: assert property (@(posedge clk) disable iff (rst)
        (lock_q != LK_OPEN) |=> $stable(start_ptr) && $stable(warm_en));

    assert_unlock_path_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q == LK_OPEN) |-> $past(lock_q == LK_HALF));
endmodule

// File: rtl/pse_script_mem.sv
module pse_script_mem
    import pse_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output step_t             rd_step
);
    logic [7:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) bytes_q[waddr] <= wdata;
    end

    assign rd_step.hi  = bytes_q[field_addr(rd_idx, 2'd0)];
    assign rd_step.lo  = bytes_q[field_addr(rd_idx, 2'd1)];
    assign rd_step.dly = bytes_q[field_addr(rd_idx, 2'd2)];
    assign rd_step.nxt = bytes_q[field_addr(rd_idx, 2'd3)];
endmodule

// File: rtl/pse_event_arb.sv
module pse_event_arb
    import pse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_sleep,
    input  logic              ev_wake3,
    input  logic              ev_wake12,
    input  logic [N_GRP-1:0]  ev_warm,
    input  logic [N_GRP-1:0]  warm_en,
    input  logic              take,
    output logic              pend_any,
    output trans_e            sel
);
    logic [N_TR-1:0] pend_q, set_v, clr_v;

    always_comb begin
        set_v            = '0;
        set_v[TR_SLEEP]  = ev_sleep;
        set_v[TR_WAKE3]  = ev_wake3;
        set_v[TR_WAKE12] = ev_wake12;
        set_v[TR_WARM]   = |(ev_warm & warm_en);
    end

    always_comb begin
        sel = TR_SLEEP;
        for (int i = 0; i < N_TR; i++)
            if (pend_q[i]) sel = trans_e'(2'(i));
    end

    always_comb begin
        clr_v = '0;
        if (take) clr_v[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_v) | set_v;
    end

    assign pend_any = |pend_q;

    assert_single_grant_R11: assert property (@(posedge clk) disable iff (rst)
        take |-> $onehot0(clr_v) && (pend_q != '0));

    assert_warm_gate_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q[TR_WARM]) |-> $past(|(ev_warm & warm_en)));
endmodule

// File: rtl/pse_walker.sv
module pse_walker
    import pse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pend_any,
    input  logic [IDX_W-1:0]  start_ptr,
    input  step_t             step,
    input  logic              msg_ready,
    output logic              take,
    output logic [IDX_W-1:0]  idx,
    output logic              msg_valid,
    output logic [MSG_W-1:0]  msg_data,
    output logic              busy
);
    walk_e            st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [7:0]       cnt_q, cnt_d;
    logic [7:0]       nxt_q, nxt_d;
    logic             adv;
    logic [7:0]       adv_to;

    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        cnt_d  = cnt_q;
        nxt_d  = nxt_q;
        take   = 1'b0;
        adv    = 1'b0;
        adv_to = '0;
        case (st_q)
            WK_IDLE: begin
                if (pend_any) begin
                    take = 1'b1;
                    if (start_ptr != END_IDX) begin
                        idx_d = start_ptr;
                        st_d  = WK_SEND;
                    end
                end
            end
            WK_SEND: begin
                if (msg_ready) begin
                    if (step.dly == 8'd0) begin
                        adv    = 1'b1;
                        adv_to = step.nxt;
                    end else begin
                        cnt_d = step.dly;
                        nxt_d = step.nxt;
                        st_d  = WK_WAIT;
                    end
                end
            end
            WK_WAIT: begin
                if (tick) begin
                    if (cnt_q == 8'd1) begin
                        adv    = 1'b1;
                        adv_to = nxt_q;
                    end else begin
                        cnt_d = cnt_q - 8'd1;
                    end
                end
            end
            default: st_d = WK_IDLE;
        endcase
        if (adv) begin
            if (is_end(adv_to)) begin
                st_d = WK_IDLE;
            end else begin
                idx_d = adv_to[IDX_W-1:0];
                st_d  = WK_SEND;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WK_IDLE;
            idx_q <= '0;
            cnt_q <= '0;
            nxt_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            cnt_q <= cnt_d;
            nxt_q <= nxt_d;
        end
    end

    assign idx       = idx_q;
    assign msg_valid = (st_q == WK_SEND);
    assign msg_data  = {step.hi, step.lo};
    assign busy      = (st_q != WK_IDLE);

    assert_msg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_data));

    assert_wait_needs_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_WAIT) && !tick |=> (st_q == WK_WAIT) && $stable(cnt_q));

    assert_end_goes_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == WK_WAIT) && tick && (cnt_q == 8'd1) && is_end(nxt_q) |=> !busy);
endmodule

// File: rtl/pse_top.sv
module pse_top
    import pse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic              cfg_wr_en,
    input  logic [3:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic              ev_sleep,
    input  logic              ev_wake3,
    input  logic              ev_wake12,
    input  logic [2:0]        ev_warm,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [15:0]       msg_data,
    output logic              busy
);
    logic [N_TR-1:0][IDX_W-1:0] start_ptr;
    logic [N_GRP-1:0]           warm_en;
    logic                       mem_we;
    logic [ADDR_W-1:0]          mem_addr;
    logic [7:0]                 mem_wdata;
    logic [IDX_W-1:0]           rd_idx;
    step_t                      step;
    logic                       take;
    logic                       pend_any;
    trans_e                     sel;

    pse_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .busy      (busy),
        .start_ptr (start_ptr),
        .warm_en   (warm_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    pse_script_mem u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_addr),
        .wdata   (mem_wdata),
        .rd_idx  (rd_idx),
        .rd_step (step)
    );

    pse_event_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .ev_sleep  (ev_sleep),
        .ev_wake3  (ev_wake3),
        .ev_wake12 (ev_wake12),
        .ev_warm   (ev_warm),
        .warm_en   (warm_en),
        .take      (take),
        .pend_any  (pend_any),
        .sel       (sel)
    );

    pse_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .tick      (slow_tick),
        .pend_any  (pend_any),
        .start_ptr (start_ptr[sel]),
        .step      (step),
        .msg_ready (msg_ready),
        .take      (take),
        .idx       (rd_idx),
        .msg_valid (msg_valid),
        .msg_data  (msg_data),
        .busy      (busy)
    );

    assert_mem_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_we);
endmodule

// File: tb/pse_top_bench.sv
module pse_top_bench;
    import pse_pkg::*;

    typedef struct {
        logic [15:0] msg;
        int          gap;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        ev_sleep = 1'b0, ev_wake3 = 1'b0, ev_wake12 = 1'b0;
    logic [2:0]  ev_warm = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [15:0] msg_data;
    logic        busy;

    int   checks = 0;
    int   errors = 0;
    int   hs_count = 0;
    int   cyc = 0;
    bit   stall_mode = 1'b0;
    exp_t exp_q[$];

    pse_top u_pse_top (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ev_sleep(ev_sleep), .ev_wake3(ev_wake3), .ev_wake12(ev_wake12),
        .ev_warm(ev_warm), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_data(msg_data), .busy(busy)
    );

    always #4 clk = ~clk;

    // slow tick every 4 cycles, ready pattern; both change just after the edge
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        slow_tick = (cyc % 4 == 0);
        msg_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: scoreboard, hold check and tick-gap measurement
    bit          gap_open = 0;
    int          gap_ticks = 0;
    bit          prev_stall = 0;
    logic [15:0] prev_data = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                chk(msg_valid === 1'b1, "R6 valid held", int'(msg_valid), 1);
                chk(msg_data === prev_data, "R6 data held", int'(msg_data), int'(prev_data));
            end
            if (msg_valid) begin
                if (gap_open) begin
                    gap_open = 0;
                    if (exp_q.size() > 0 && exp_q[0].gap >= 0)
                        chk(gap_ticks == exp_q[0].gap, "R7 tick gap", gap_ticks, exp_q[0].gap);
                end
                if (msg_ready) begin
                    hs_count++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected message", int'(msg_data), 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(msg_data === e.msg, e.req, int'(msg_data), int'(e.msg));
                    end
                    gap_open  = 1;
                    gap_ticks = 0;
                end
            end else if (gap_open && slow_tick) begin
                gap_ticks++;
            end
            prev_stall = msg_valid && !msg_ready;
            prev_data  = msg_data;
        end
    end

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic memw(input logic [7:0] a, input logic [7:0] d);
        wr(SEL_MADDR, a);
        wr(SEL_MDATA, d);
    endtask

    task automatic load_step(input int idx, input logic [15:0] m, input logic [7:0] dly,
                             input logic [7:0] nxt);
        memw(8'(idx * 4 + 0), m[15:8]);
        memw(8'(idx * 4 + 1), m[7:0]);
        memw(8'(idx * 4 + 2), dly);
        memw(8'(idx * 4 + 3), nxt);
    endtask

    task automatic unlock();
        wr(SEL_KEY, KEY_A);
        wr(SEL_KEY, KEY_B);
    endtask

    task automatic pulse(input bit s, input bit w12, input bit w3, input logic [2:0] wm);
        ev_sleep = s; ev_wake12 = w12; ev_wake3 = w3; ev_warm = wm;
        @(negedge clk);
        ev_sleep = 0; ev_wake12 = 0; ev_wake3 = 0; ev_warm = '0;
    endtask

    task automatic expect_msg(input logic [15:0] m, input int gap, input string req);
        exp_t e;
        e.msg = m; e.gap = gap; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic expect_prog_a(input logic [15:0] last_msg, input string req);
        expect_msg(16'h1234, -1, req);
        expect_msg(16'hABCD, 2, req);
        expect_msg(last_msg, 0, req);
    endtask

    task automatic drain(input string req);
        int n = 0;
        repeat (3) @(negedge clk);
        while ((busy || exp_q.size() != 0) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(busy == 1'b0, req, int'(busy), 0);
        exp_q.delete();
    endtask

    task automatic expect_silence(input string req);
        int snap = hs_count;
        repeat (12) @(negedge clk);
        chk(hs_count == snap, req, hs_count - snap, 0);
        chk(busy == 1'b0, req, int'(busy), 0);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(msg_valid == 1'b0, "R1 msg_valid", int'(msg_valid), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);

        // R9/R1: pointers empty after reset, no message for any event
        pulse(1, 1, 1, 3'b000);
        expect_silence("R9 empty pointer after reset");

        // R4: program A at 2 -> 5 -> 6, B at 10, C at 11, D at 12
        load_step(2, 16'h1234, 8'd2, 8'd5);
        load_step(5, 16'hABCD, 8'd0, 8'd6);
        load_step(6, 16'h0F0F, 8'd1, 8'h3F);
        load_step(10, 16'h2222, 8'd0, 8'h3F);
        load_step(11, 16'h3333, 8'd0, 8'h40);
        load_step(12, 16'h4444, 8'd0, 8'h3F);

        // R2: pointer write while locked ignored
        wr(4'(SEL_PTR0 + TR_SLEEP), 8'd2);
        pulse(1, 0, 0, 3'b000);
        expect_silence("R2 locked pointer write");

        // R3: intervening write breaks unlock
        wr(SEL_KEY, KEY_A);
        wr(SEL_MADDR, 8'd0);
        wr(SEL_KEY, KEY_B);
        wr(4'(SEL_PTR0 + TR_SLEEP), 8'd2);
        pulse(1, 0, 0, 3'b000);
        expect_silence("R3 intervening write");
        // R3: keys out of order
        wr(SEL_KEY, KEY_B);
        wr(SEL_KEY, KEY_A);
        wr(4'(SEL_PTR0 + TR_SLEEP), 8'd2);
        wr(SEL_KEY, 8'h00);
        pulse(1, 0, 0, 3'b000);
        expect_silence("R3 keys reversed");

        // R2: proper unlock, program pointers
        unlock();
        wr(4'(SEL_PTR0 + TR_SLEEP), 8'd2);
        wr(4'(SEL_PTR0 + TR_WAKE12), 8'd10);
        wr(4'(SEL_PTR0 + TR_WAKE3), 8'd11);
        wr(4'(SEL_PTR0 + TR_WARM), 8'd12);
        wr(SEL_KEY, 8'h00);

        // R5 latency, R4/R7/R8 content, gaps and end
        expect_prog_a(16'h0F0F, "R4 program A");
        ev_sleep = 1'b1;
        @(negedge clk);
        ev_sleep = 1'b0;
        chk(msg_valid == 1'b0, "R5 not yet valid", int'(msg_valid), 0);
        @(negedge clk);
        chk(msg_valid == 1'b1, "R5 valid after two edges", int'(msg_valid), 1);
        chk(msg_data == 16'h1234, "R5 first message", int'(msg_data), 16'h1234);
        drain("R8 program A ends");

        // R6 with back-pressure
        stall_mode = 1'b1;
        expect_prog_a(16'h0F0F, "R6 program A stalled");
        pulse(1, 0, 0, 3'b000);
        drain("R6 program A stalled ends");
        stall_mode = 1'b0;

        // R2 relock held: pointer write after relock ignored
        wr(4'(SEL_PTR0 + TR_SLEEP), 8'd10);
        expect_prog_a(16'h0F0F, "R2 relocked pointer kept");
        pulse(1, 0, 0, 3'b000);
        drain("R2 relocked run");

        // R10 warm reset gating
        pulse(0, 0, 0, 3'b001);
        expect_silence("R10 warm disabled group 0");
        unlock();
        wr(4'(SEL_GRP0 + 1), 8'h10);
        wr(SEL_KEY, 8'h00);
        pulse(0, 0, 0, 3'b001);
        expect_silence("R10 group 0 still disabled");
        expect_msg(16'h4444, -1, "R10 warm enabled group 1");
        pulse(0, 0, 0, 3'b010);
        drain("R10 warm run");

        // R11 priority: all at once
        expect_msg(16'h4444, -1, "R11 warm first");
        expect_msg(16'h2222, -1, "R11 wake12 second");
        expect_msg(16'h3333, -1, "R11 wake3 third");
        expect_prog_a(16'h0F0F, "R11 sleep last");
        pulse(1, 1, 1, 3'b010);
        drain("R11 priority");

        // R11 event during a run is held
        expect_prog_a(16'h0F0F, "R11 running program");
        expect_msg(16'h2222, -1, "R11 held wake12");
        pulse(1, 0, 0, 3'b000);
        repeat (3) @(negedge clk);
        pulse(0, 1, 0, 3'b000);
        drain("R11 held event");

        // R12 memory write while busy ignored
        expect_prog_a(16'h0F0F, "R12 busy run");
        pulse(1, 0, 0, 3'b000);
        wr(SEL_MADDR, 8'd24);
        wr(SEL_MDATA, 8'hEE);
        drain("R12 busy run ends");
        expect_prog_a(16'h0F0F, "R12 content unchanged");
        pulse(1, 0, 0, 3'b000);
        drain("R12 replay");

        // R4 idle write takes effect at the latched address
        wr(SEL_MDATA, 8'hEE);
        expect_prog_a(16'hEE0F, "R4 idle write");
        pulse(1, 0, 0, 3'b000);
        drain("R4 idle write run");

        report();
    end
endmodule